// File: doc/BRIEF.md
# Dual Quad-SPI Flash Lane Router

This block sits between a serial engine that only knows how to talk to one quad-SPI flash and a board that carries two flash devices. The engine drives one logical chip select, a serial clock, a transmit word and a per-clock direction flag. The router fans these out to two device ports, each with its own chip select, clock and 4-bit data bus. It also assembles the read word from the data the devices return.

A 32-bit configuration word picks the routing. In single mode only the lower device is used. In stacked mode both devices hang off the lower bus and clock, and a page bit decides which one gets its chip select. In parallel mode both devices are selected together on their own buses. Each transfer word is then split by bit parity: even bits go to the lower device and odd bits to the upper one, and reads are merged back the same way. This gives two nibbles, one full byte, per serial clock.

Changes to the configuration are latched only while the engine holds chip select high. Mode or page writes that arrive during a transfer therefore wait until the transfer ends. Opcodes, addresses and command sequencing stay in the engine.

Top module: `qspi_dual_router`

## Requirements
- R1: While rst_ni is low, both lo_cs_no and up_cs_no are high, and the clock edge that releases reset leaves them high. The configuration after reset is single mode with the lower page.
- R2: Single mode is selected when cfg_i bit 30 is 0. In this mode the lower port carries the chip select, eng_sclk_i and the lanes eng_tx_i[3:0]. eng_rx_o equals {4'b0, lo_io_i}. up_cs_no stays high.
- R3: Stacked mode is selected when cfg_i bit 30 is 1 and bit 29 is 0. With cfg_i bit 28 at 0 in this mode, only lo_cs_no follows the engine chip select and up_cs_no stays high. Data still uses the lower bus and eng_rx_o = {4'b0, lo_io_i}.
- R4: In stacked mode with cfg_i bit 28 at 1, only up_cs_no follows the engine chip select and lo_cs_no stays high. Data, clock and read path stay on the lower bus pins.
- R5: Parallel mode is selected when cfg_i bits 30 and 29 are both 1. Both chip selects follow the engine chip select together, and both clock outputs carry eng_sclk_i.
- R6: In parallel mode lo_io_o[i] = eng_tx_i[2i] and up_io_o[i] = eng_tx_i[2i+1] for lane i = 0..3.
- R7: In parallel mode eng_rx_o[2i] = lo_io_i[i] and eng_rx_o[2i+1] = up_io_i[i].
- R8: Every lane enable of a bus in use equals eng_oe_i while the engine chip select is low, and 0 while it is high. Outside parallel mode up_io_oe_o, up_io_o and up_sclk_o are all 0.
- R9: The mode and page bits are sampled on a rising clk_i edge only when eng_cs_ni is high there. A change made while eng_cs_ni is low takes effect after the first edge that sees eng_cs_ni high.
- R10: While eng_cs_ni is high, both chip selects are high. cfg_i bit 28 has no effect in single or parallel mode, and cfg_i bits other than 30..28 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, one serial bit period per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Configuration word (bit 30 two devices, bit 29 separate buses, bit 28 upper page) |
| eng_cs_ni | input | 1 | Engine logical chip select, active low |
| eng_sclk_i | input | 1 | Engine serial clock |
| eng_tx_i | input | 8 | Transmit word for this clock |
| eng_oe_i | input | 1 | Drive data lines this clock |
| eng_rx_o | output | 8 | Read word assembled from the devices |
| lo_cs_no | output | 1 | Lower device chip select, active low |
| lo_sclk_o | output | 1 | Lower (shared) bus clock |
| lo_io_o | output | 4 | Lower bus data out |
| lo_io_oe_o | output | 4 | Lower bus per-lane output enable |
| lo_io_i | input | 4 | Lower bus data in |
| up_cs_no | output | 1 | Upper device chip select, active low |
| up_sclk_o | output | 1 | Upper bus clock |
| up_io_o | output | 4 | Upper bus data out |
| up_io_oe_o | output | 4 | Upper bus per-lane output enable |
| up_io_i | input | 4 | Upper bus data in |

## Verification
The bench targets a configuration write issued in the middle of a transfer. A router that applied it at once would switch chip selects or split the word partway through a device access. It also drives words that differ only in even or odd bits, so a swapped or shifted parity mapping shows up as a wrong nibble on one bus or a scrambled read byte. The page bit is toggled in single and parallel modes and junk bits are set outside 30..28; a decoder that listened to them would select the wrong device. Reset checks catch a chip select that drops early, and enable checks catch a bus that is driven while deselected.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_STACKED  = 2'd1,
    MODE_PARALLEL = 2'd2
  } route_mode_e;
endpackage

// File: rtl/qdr_mode_latch.sv
module qdr_mode_latch
  import qdr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int TWO_BIT  = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             idle_i,
  output route_mode_e      mode_o,
  output logic             upper_o,
  output logic             active_o
);
  route_mode_e mode_d, mode_q;
  logic        upper_q, active_q;

  always_comb begin
    if (!cfg_i[TWO_BIT])     mode_d = MODE_SINGLE;
    else if (cfg_i[SEP_BIT]) mode_d = MODE_PARALLEL;
    else                     mode_d = MODE_STACKED;
  end

  // update only between transfers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SINGLE;
      upper_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      active_q <= 1'b1;
      if (idle_i) begin
        mode_q  <= mode_d;
        upper_q <= cfg_i[PAGE_BIT];
      end
    end
  end

  assign mode_o   = mode_q;
  assign upper_o  = upper_q;
  assign active_o = active_q;
endmodule

// File: rtl/qdr_lane_split.sv
module qdr_lane_split #(
  parameter int LANES = 4,
  localparam int WORD_W = 2 * LANES
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [LANES-1:0]  even_o,
  output logic [LANES-1:0]  odd_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign even_o[g] = word_i[2*g];
    assign odd_o[g]  = word_i[2*g+1];
  end
endmodule

// File: rtl/qdr_lane_merge.sv
module qdr_lane_merge #(
  parameter int LANES = 4,
  localparam int WORD_W = 2 * LANES
) (
  input  logic [LANES-1:0]  even_i,
  input  logic [LANES-1:0]  odd_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[2*g]   = even_i[g];
    assign word_o[2*g+1] = odd_i[g];
  end
endmodule

// File: rtl/qspi_dual_router.sv
module qspi_dual_router
  import qdr_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CFG_W    = 32,
  parameter int TWO_BIT  = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28,
  localparam int WORD_W  = 2 * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              eng_cs_ni,
  input  logic              eng_sclk_i,
  input  logic [WORD_W-1:0] eng_tx_i,
  input  logic              eng_oe_i,
  output logic [WORD_W-1:0] eng_rx_o,
  output logic              lo_cs_no,
  output logic              lo_sclk_o,
  output logic [LANES-1:0]  lo_io_o,
  output logic [LANES-1:0]  lo_io_oe_o,
  input  logic [LANES-1:0]  lo_io_i,
  output logic              up_cs_no,
  output logic              up_sclk_o,
  output logic [LANES-1:0]  up_io_o,
  output logic [LANES-1:0]  up_io_oe_o,
  input  logic [LANES-1:0]  up_io_i
);
  route_mode_e       mode_q;
  logic              upper_q, active_q, cs_eff;
  logic [LANES-1:0]  tx_even, tx_odd;
  logic [WORD_W-1:0] rx_merged;

  qdr_mode_latch #(
    .CFG_W(CFG_W), .TWO_BIT(TWO_BIT), .SEP_BIT(SEP_BIT), .PAGE_BIT(PAGE_BIT)
  ) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg_i),
    .idle_i  (eng_cs_ni),
    .mode_o  (mode_q),
    .upper_o (upper_q),
    .active_o(active_q)
  );

  qdr_lane_split #(.LANES(LANES)) u_split (
    .word_i(eng_tx_i), .even_o(tx_even), .odd_o(tx_odd)
  );

  qdr_lane_merge #(.LANES(LANES)) u_merge (
    .even_i(lo_io_i), .odd_i(up_io_i), .word_o(rx_merged)
  );

  // chip select held off until the first edge out of reset
  assign cs_eff    = eng_cs_ni | ~active_q;
  assign lo_sclk_o = eng_sclk_i;

  always_comb begin
    lo_cs_no   = cs_eff;
    up_cs_no   = 1'b1;
    up_sclk_o  = 1'b0;
    lo_io_o    = eng_tx_i[LANES-1:0];
    lo_io_oe_o = {LANES{eng_oe_i & ~cs_eff}};
    up_io_o    = '0;
    up_io_oe_o = '0;
    eng_rx_o   = {{LANES{1'b0}}, lo_io_i};
    unique case (mode_q)
      MODE_STACKED: begin
        lo_cs_no = cs_eff | upper_q;
        up_cs_no = cs_eff | ~upper_q;
      end
      MODE_PARALLEL: begin
        up_cs_no   = cs_eff;
        up_sclk_o  = eng_sclk_i;
        lo_io_o    = tx_even;
        up_io_o    = tx_odd;
        up_io_oe_o = {LANES{eng_oe_i & ~cs_eff}};
        eng_rx_o   = rx_merged;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qdr_router_checker.sv
module qdr_router_checker
  import qdr_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eng_cs_ni,
  input logic             lo_cs_no,
  input logic             up_cs_no,
  input logic             up_sclk_o,
  input logic [LANES-1:0] lo_io_oe_o,
  input logic [LANES-1:0] up_io_oe_o,
  input route_mode_e      mode_i
);
  AST_RESET_CS_HIGH: assert property (@(posedge clk_i)
    !rst_ni |-> (lo_cs_no && up_cs_no)) else $error("reset cs"); // R1

  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cs_ni |-> (lo_cs_no && up_cs_no)) else $error("idle cs"); // R10

  AST_STACKED_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STACKED) |-> (lo_cs_no || up_cs_no)) else $error("stacked cs"); // R4

  AST_PARALLEL_PAIR_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PARALLEL) |-> (lo_cs_no == up_cs_no)) else $error("parallel cs"); // R5

  AST_UPPER_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_PARALLEL) |-> (up_io_oe_o == '0 && !up_sclk_o)) else $error("upper bus"); // R8

  AST_OE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_cs_no && up_cs_no) |-> (lo_io_oe_o == '0 && up_io_oe_o == '0)) else $error("oe"); // R8

  AST_MODE_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!eng_cs_ni) |-> $stable(mode_i)) else $error("mode change busy"); // R9
endmodule

bind qspi_dual_router qdr_router_checker #(.LANES(LANES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .eng_cs_ni (eng_cs_ni),
  .lo_cs_no  (lo_cs_no),
  .up_cs_no  (up_cs_no),
  .up_sclk_o (up_sclk_o),
  .lo_io_oe_o(lo_io_oe_o),
  .up_io_oe_o(up_io_oe_o),
  .mode_i    (mode_q)
);

// File: tb/sim_qspi_dual_router.sv
`timescale 1ns/1ps
module sim_qspi_dual_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic       cs_n = 1'b1, sclk = 1'b0, oe = 1'b0;
  logic [7:0] tx = '0, rx;
  logic       lo_cs, up_cs, lo_sclk, up_sclk;
  logic [3:0] lo_io, lo_oe, lo_in = '0, up_io, up_oe, up_in = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  bit m_run = 0;
  bit [2:0] m_cfg = '0;  // {two, sep, page}

  always #10 clk = ~clk;

  qspi_dual_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .eng_cs_ni(cs_n),
    .eng_sclk_i(sclk), .eng_tx_i(tx), .eng_oe_i(oe), .eng_rx_o(rx),
    .lo_cs_no(lo_cs), .lo_sclk_o(lo_sclk), .lo_io_o(lo_io), .lo_io_oe_o(lo_oe),
    .lo_io_i(lo_in), .up_cs_no(up_cs), .up_sclk_o(up_sclk), .up_io_o(up_io),
    .up_io_oe_o(up_oe), .up_io_i(up_in)
  );

  task automatic step(input string tag, input bit c, input bit s, input bit [7:0] t,
                      input bit o, input bit [31:0] cf, input bit [3:0] li, input bit [3:0] ui);
    bit ecs, e_lcs, e_ucs, e_usck;
    bit [3:0] e_lio, e_loe, e_uio, e_uoe;
    bit [7:0] e_rx;
    bit [27:0] exp_v, act_v;
    @(negedge clk);
    cs_n = c; sclk = s; tx = t; oe = o; cfg = cf; lo_in = li; up_in = ui;
    @(posedge clk);
    if (rst_n) begin
      m_run = 1;
      if (c) m_cfg = {cf[30], cf[29], cf[28]};
    end
    #5;
    ecs = c | !m_run;
    e_lcs = ecs; e_ucs = 1; e_usck = 0;
    e_lio = t[3:0]; e_loe = (o && !ecs) ? 4'hF : 4'h0;
    e_uio = 0; e_uoe = 0; e_rx = {4'h0, li};
    if (m_cfg[2] && !m_cfg[1]) begin
      e_lcs = ecs | m_cfg[0];
      e_ucs = ecs | !m_cfg[0];
    end else if (m_cfg[2] && m_cfg[1]) begin
      e_ucs = ecs; e_usck = s; e_uoe = e_loe;
      for (int i = 0; i < 4; i++) begin
        e_lio[i] = t[2*i]; e_uio[i] = t[2*i+1];
        e_rx[2*i] = li[i]; e_rx[2*i+1] = ui[i];
      end
    end
    exp_v = {e_lcs, e_ucs, s, e_usck, e_lio, e_loe, e_uio, e_uoe, e_rx};
    act_v = {lo_cs, up_cs, lo_sclk, up_sclk, lo_io, lo_oe, up_io, up_oe, rx};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%07h expected=%07h (cs,cs,sck,sck,lio,loe,uio,uoe,rx)",
               tag, act_v, exp_v);
    end
  endtask

  task automatic burst(input string tag, input bit [31:0] cf, input int n);
    for (int k = 0; k < n; k++)
      step(tag, 1'b0, k[0], 8'($urandom), 1'($urandom), cf, 4'($urandom), 4'($urandom));
  endtask

  localparam bit [31:0] TWO = 32'h4000_0000, SEP = 32'h2000_0000, PG = 32'h1000_0000;

  initial begin
    // R1: reset state
    for (int k = 0; k < 3; k++) step("R1", 1'b0, 1'b1, 8'hFF, 1'b1, TWO | SEP, 4'hA, 4'h5);
    rst_n = 1'b1;
    step("R1", 1'b1, 1'b0, 8'h00, 1'b1, 32'h0, 4'h3, 4'hC);
    // R2: single mode, R8 direction
    burst("R2", 32'h0, 8);
    step("R8", 1'b0, 1'b1, 8'h5A, 1'b0, 32'h0, 4'h9, 4'h6);
    step("R8", 1'b1, 1'b0, 8'h5A, 1'b1, 32'h0, 4'h9, 4'h6);
    // R9: stacked request mid-transfer is held
    step("R9", 1'b0, 1'b1, 8'h0F, 1'b1, TWO, 4'h1, 4'h2);
    burst("R9", TWO, 4);
    step("R9", 1'b1, 1'b0, 8'h00, 1'b0, TWO, 4'h0, 4'h0);
    // R3: stacked, lower page
    burst("R3", TWO, 8);
    // R4: stacked, upper page
    step("R4", 1'b1, 1'b0, 8'h00, 1'b0, TWO | PG, 4'h0, 4'h0);
    burst("R4", TWO | PG, 8);
    // R5..R7: parallel with parity patterns
    step("R5", 1'b1, 1'b0, 8'h00, 1'b0, TWO | SEP, 4'h0, 4'h0);
    step("R6", 1'b0, 1'b1, 8'h55, 1'b1, TWO | SEP, 4'hF, 4'h0);
    step("R6", 1'b0, 1'b0, 8'hAA, 1'b1, TWO | SEP, 4'h0, 4'hF);
    step("R7", 1'b0, 1'b1, 8'h01, 1'b0, TWO | SEP, 4'h1, 4'h8);
    step("R7", 1'b0, 1'b0, 8'h80, 1'b0, TWO | SEP, 4'h8, 4'h1);
    burst("R5", TWO | SEP, 12);
    // R10: page and junk bits ignored in parallel and single
    step("R10", 1'b1, 1'b0, 8'h00, 1'b1, TWO | SEP | PG | 32'h8FFF_FFFF, 4'h0, 4'h0);
    burst("R10", TWO | SEP | PG | 32'h8FFF_FFFF, 6);
    step("R10", 1'b1, 1'b1, 8'h3C, 1'b1, PG | SEP | 32'h0123_4567, 4'h7, 4'h7);
    burst("R10", PG | SEP | 32'h0123_4567, 6);
    // R9: parallel requested while busy, held until cs high
    burst("R9", TWO | SEP, 5);
    step("R9", 1'b1, 1'b0, 8'h00, 1'b0, TWO | SEP, 4'h0, 4'h0);
    burst("R9", 32'h0, 5);
    step("R9", 1'b1, 1'b0, 8'h00, 1'b0, 32'h0, 4'h0, 4'h0);
    burst("R2", 32'h0, 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule